// File: doc/BRIEF.md
# SMBus Byte Transaction Sequencer

This block acts as an SMBus master for the four single-byte transactions: receive byte, read byte, send byte and write byte. A client hands it one request. The request carries an operation code, a 7-bit target address, a command byte and a data byte. The sequencer then breaks the transaction into a series of byte-level commands for a downstream bus engine. Each command is a byte write, a byte read or a STOP, and each byte command can be preceded by a START or a repeated START. Between commands it waits for the engine's completion event.

When the transaction finishes, the sequencer pulses `done`. In that cycle it also presents a 2-bit status and, for reads, the byte taken from the target. It detects three kinds of failure and gives each its own status code: a NACK from the target, loss of arbitration, and an engine that stays silent for too long. Each wait is bounded by a programmable number of microsecond ticks. Operation codes outside the four supported transactions are refused at once and cause no bus activity.

Top module: `smb_byte_seq`

## Requirements
- R1: The first command of every supported transaction is a byte write that carries START, with the target address in bits 7:1 and bit 0 set to 1 only for a receive byte (op 0). Every later address byte uses bit 0 = 1 for a read phase and bit 0 = 0 for a write phase.
- R2: Receive byte (op 0) issues, in order: START + address-read, then a read, then STOP. `rd_data` returns the byte that was read.
- R3: Read byte (op 1) issues, in order: START + address-write, the command byte, a repeated START + address-read with no STOP before it, a read, and then STOP.
- R4: Send byte (op 2) issues, in order: START + address-write, the data byte, then STOP.
- R5: Write byte (op 3) issues, in order: START + address-write, the command byte, the data byte, then STOP. It never issues a repeated START.
- R6: An operation code of 4 to 7 is accepted and gives `done` with status 3 on the next cycle. It issues no engine command.
- R7: A NACK on any byte stops further bytes. The sequencer then issues a STOP and finishes with status 1.
- R8: Arbitration loss on a byte ends the transaction at once with status 2 and issues no STOP.
- R9: If no completion event arrives within `wait_limit` ticks of `TICK_CYCLES` clocks each, the transaction ends with status 3.
- R10: `req_ready` is high only while idle. `done` is a single-cycle pulse that occurs while idle, and `status` and `rd_data` are valid in that cycle. A successful transaction gives status 0.
- R11: Each engine command is a one-cycle pulse on `eng_go`. No new command is issued until the previous one completes, and no command is issued while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_op | input | 3 | 0 receive, 1 read, 2 send, 3 write, 4-7 unsupported |
| req_addr | input | 7 | Target address |
| req_cmd | input | 8 | Command byte |
| req_data | input | 8 | Data byte for send and write |
| wait_limit | input | LIMIT_W | Completion timeout in ticks |
| done | output | 1 | Transaction finished pulse |
| status | output | 2 | 0 ok, 1 NACK, 2 arbitration lost, 3 timeout or unsupported |
| rd_data | output | 8 | Byte read from the target |
| eng_go | output | 1 | Engine command strobe |
| eng_start | output | 1 | Precede this byte with START or repeated START |
| eng_kind | output | 2 | 0 write byte, 1 read byte, 2 STOP |
| eng_byte | output | 8 | Byte to transmit |
| eng_done | input | 1 | Engine completion event |
| eng_nack | input | 1 | Completion carried a NACK |
| eng_arb | input | 1 | Completion carried arbitration loss |
| eng_rdata | input | 8 | Byte received by the engine |

## Verification
The assertions assume that the engine raises `eng_done` only while a command is outstanding, never in the cycle in which `eng_go` is high, and holds it for exactly one cycle. They also assume that the client presents a request only when `req_ready` is high or accepts that it is taken in the cycle it appears. The bench's target model replies between one and four cycles after each strobe, and it stays silent only in the timeout case. Requests are applied one at a time, and the bench waits for `done` before it presents the next one.

// File: rtl/smb_byte_seq.sv
module smb_byte_seq #(
  parameter int TICK_CYCLES = 100,
  parameter int LIMIT_W     = 8
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [2:0]         req_op,
  input  logic [6:0]         req_addr,
  input  logic [7:0]         req_cmd,
  input  logic [7:0]         req_data,
  input  logic [LIMIT_W-1:0] wait_limit,
  output logic               done,
  output logic [1:0]         status,
  output logic [7:0]         rd_data,
  output logic               eng_go,
  output logic               eng_start,
  output logic [1:0]         eng_kind,
  output logic [7:0]         eng_byte,
  input  logic               eng_done,
  input  logic               eng_nack,
  input  logic               eng_arb,
  input  logic [7:0]         eng_rdata
);

  localparam int TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_STOP = 2'd2;
  localparam logic [1:0] ST_OK = 2'd0, ST_NACK = 2'd1, ST_ARB = 2'd2, ST_FAIL = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_STOP, S_SWAIT} st_t;

  st_t          st;
  logic [1:0]   op_q, step, pend;
  logic [6:0]   addr_q;
  logic [7:0]   cmd_q, data_q;
  logic [TW-1:0]      tick_cnt;
  logic [LIMIT_W-1:0] ticks;
  logic         d_start, d_last, waiting, expired;
  logic [1:0]   d_kind;
  logic [7:0]   d_byte;

  always_comb begin
    d_start = 1'b0;
    d_kind  = K_WR;
    d_byte  = 8'h00;
    d_last  = 1'b0;
    case (op_q)
      2'd0: if (step == 2'd0) begin d_start = 1'b1; d_byte = {addr_q, 1'b1}; end
            else begin d_kind = K_RD; d_last = 1'b1; end
      2'd1: case (step)
              2'd0:    begin d_start = 1'b1; d_byte = {addr_q, 1'b0}; end
              2'd1:    d_byte = cmd_q;
              2'd2:    begin d_start = 1'b1; d_byte = {addr_q, 1'b1}; end
              default: begin d_kind = K_RD; d_last = 1'b1; end
            endcase
      2'd2: if (step == 2'd0) begin d_start = 1'b1; d_byte = {addr_q, 1'b0}; end
            else begin d_byte = data_q; d_last = 1'b1; end
      default: case (step)
              2'd0:    begin d_start = 1'b1; d_byte = {addr_q, 1'b0}; end
              2'd1:    d_byte = cmd_q;
              default: begin d_byte = data_q; d_last = 1'b1; end
            endcase
    endcase
  end

  assign req_ready = (st == S_IDLE);
  assign eng_go    = (st == S_ISSUE) || (st == S_STOP);
  assign eng_start = (st == S_ISSUE) && d_start;
  assign eng_kind  = (st == S_STOP) ? K_STOP : d_kind;
  assign eng_byte  = (st == S_STOP) ? 8'h00 : d_byte;
  assign waiting   = (st == S_WAIT) || (st == S_SWAIT);
  assign expired   = waiting && (ticks == wait_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      ticks    <= '0;
    end else if (!waiting) begin
      tick_cnt <= '0;
      ticks    <= '0;
    end else if (tick_cnt == TW'(TICK_CYCLES - 1)) begin
      tick_cnt <= '0;
      ticks    <= ticks + 1'b1;
    end else begin
      tick_cnt <= tick_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_q    <= 2'd0;
      step    <= 2'd0;
      pend    <= ST_OK;
      addr_q  <= '0;
      cmd_q   <= '0;
      data_q  <= '0;
      done    <= 1'b0;
      status  <= ST_OK;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          op_q    <= req_op[1:0];
          addr_q  <= req_addr;
          cmd_q   <= req_cmd;
          data_q  <= req_data;
          step    <= 2'd0;
          pend    <= ST_OK;
          rd_data <= '0;
          if (req_op[2]) begin
            done   <= 1'b1;
            status <= ST_FAIL;
          end else begin
            st <= S_ISSUE;
          end
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: begin
          if (eng_done) begin
            if (eng_arb) begin
              st <= S_IDLE; done <= 1'b1; status <= ST_ARB;
            end else if (eng_nack) begin
              pend <= ST_NACK; st <= S_STOP;
            end else begin
              if (d_kind == K_RD) rd_data <= eng_rdata;
              if (d_last) st <= S_STOP;
              else begin step <= step + 2'd1; st <= S_ISSUE; end
            end
          end else if (expired) begin
            st <= S_IDLE; done <= 1'b1; status <= ST_FAIL;
          end
        end
        S_STOP: st <= S_SWAIT;
        S_SWAIT: begin
          if (eng_done) begin
            st <= S_IDLE; done <= 1'b1; status <= eng_arb ? ST_ARB : pend;
          end else if (expired) begin
            st <= S_IDLE; done <= 1'b1; status <= ST_FAIL;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_go_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go |=> !eng_go);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !eng_go);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
  p_unsup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op[2]) |=> (done && status == ST_FAIL && !eng_go));
  p_first_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_op[2]) |=>
      (eng_go && eng_start && eng_kind == K_WR && eng_byte[7:1] == $past(req_addr)
       && eng_byte[0] == ($past(req_op) == 3'd0)));
  p_arb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && eng_done && eng_arb) |=> (done && status == ST_ARB && !eng_go));
  p_nack_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && eng_done && eng_nack && !eng_arb) |=> (eng_go && eng_kind == K_STOP));

endmodule

// File: tb/smb_byte_seq_bench.sv
module smb_byte_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS = 100;
  localparam logic [6:0] TGT = 7'h33;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, done, eng_go, eng_start;
  logic [2:0] req_op = '0;
  logic [6:0] req_addr = '0;
  logic [7:0] req_cmd = '0, req_data = '0, rd_data, eng_byte;
  logic [7:0] wait_limit = 8'd10;
  logic [1:0] status, eng_kind;
  logic eng_done = 1'b0, eng_nack = 1'b0, eng_arb = 1'b0;
  logic [7:0] eng_rdata = '0;

  smb_byte_seq #(.TICK_CYCLES(TICKS), .LIMIT_W(8)) u_smb_byte_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_cmd(req_cmd), .req_data(req_data),
    .wait_limit(wait_limit), .done(done), .status(status), .rd_data(rd_data),
    .eng_go(eng_go), .eng_start(eng_start), .eng_kind(eng_kind), .eng_byte(eng_byte),
    .eng_done(eng_done), .eng_nack(eng_nack), .eng_arb(eng_arb), .eng_rdata(eng_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0, ngo = 0;
  logic [23:0] glog = '0;
  bit mute = 0, arb_mode = 0, sel = 0, exp_cmd = 0;
  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  logic [7:0] ptr = 0, ref_ptr = 0;

  initial begin
    int pend_cnt;
    bit p_nack, p_arb;
    logic [7:0] p_rd;
    pend_cnt = 0; p_nack = 0; p_arb = 0; p_rd = 0;
    forever begin
      @(negedge clk);
      eng_done = 0; eng_nack = 0; eng_arb = 0;
      if (pend_cnt > 0) begin
        pend_cnt--;
        if (pend_cnt == 0) begin
          eng_done = 1; eng_nack = p_nack; eng_arb = p_arb; eng_rdata = p_rd;
        end
      end
      if (eng_go) begin
        glog = {glog[20:0], eng_start, eng_kind};
        ngo++;
        p_nack = 0; p_arb = arb_mode; p_rd = 8'h00;
        if (eng_kind == 2'd0) begin
          if (eng_start) begin
            sel = (eng_byte[7:1] == TGT);
            p_nack = !sel;
            exp_cmd = !eng_byte[0];
          end else if (!sel) begin
            p_nack = 1;
          end else if (exp_cmd) begin
            ptr = eng_byte; exp_cmd = 0;
          end else begin
            mem[ptr] = eng_byte;
          end
        end else if (eng_kind == 2'd1) begin
          p_rd = mem[ptr];
        end
        if (!mute) pend_cnt = 1 + int'($urandom % 4);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] push(input logic [23:0] l, input logic [2:0] c);
    return {l[20:0], c};
  endfunction

  task automatic exp_seq(input logic [1:0] op, input bit hit, output logic [23:0] lg, output int n);
    lg = '0;
    lg = push(lg, 3'b100);
    n = 1;
    if (hit) begin
      case (op)
        2'd0: begin lg = push(lg, 3'b001); n++; end
        2'd1: begin lg = push(lg, 3'b000); lg = push(lg, 3'b100); lg = push(lg, 3'b001); n += 3; end
        2'd2: begin lg = push(lg, 3'b000); n++; end
        default: begin lg = push(lg, 3'b000); lg = push(lg, 3'b000); n += 2; end
      endcase
    end
    lg = push(lg, 3'b010);
    n++;
  endtask

  task automatic run(input logic [2:0] op, input logic [6:0] a, input logic [7:0] c, input logic [7:0] d,
                     output logic [1:0] st, output logic [7:0] rd, output int cyc);
    glog = '0; ngo = 0;
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_cmd = c; req_data = d;
    @(negedge clk);
    req_valid = 0;
    cyc = 1;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    st = status; rd = rd_data;
    chk(done === 1'b1 && req_ready === 1'b1, "R10 done while idle", {30'd0, done, req_ready}, 32'h3);
    @(negedge clk);
    chk(done === 1'b0, "R10 done single pulse", {31'd0, done}, 0);
    repeat (6) @(negedge clk);
  endtask

  task automatic normal(input logic [2:0] op, input logic [6:0] a, input logic [7:0] c, input logic [7:0] d);
    logic [1:0] st; logic [7:0] rd; int cyc, n; logic [23:0] lg; bit hit;
    logic [7:0] erd;
    hit = (a == TGT);
    erd = 8'h00;
    if (hit) begin
      case (op[1:0])
        2'd0: erd = ref_mem[ref_ptr];
        2'd1: begin ref_ptr = c; erd = ref_mem[c]; end
        2'd2: ref_ptr = d;
        default: begin ref_ptr = c; ref_mem[c] = d; end
      endcase
    end
    run(op, a, c, d, st, rd, cyc);
    exp_seq(op[1:0], hit, lg, n);
    case (op[1:0])
      2'd0: chk(glog == lg && ngo == n, "R2 receive sequence", glog, lg);
      2'd1: chk(glog == lg && ngo == n, "R3 read sequence", glog, lg);
      2'd2: chk(glog == lg && ngo == n, "R4 send sequence", glog, lg);
      default: chk(glog == lg && ngo == n, "R5 write sequence", glog, lg);
    endcase
    if (hit) chk(st == 2'd0, "R10 ok status", st, 0);
    else chk(st == 2'd1, "R7 nack status", st, 1);
    if (hit && op[1:0] <= 2'd1) chk(rd == erd, "R2 R3 read data", rd, erd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [1:0] st; logic [7:0] rd; int cyc;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3); ref_mem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready === 1'b1 && done === 1'b0 && eng_go === 1'b0 && status === 2'd0,
        "R10 reset state", {28'd0, req_ready, done, eng_go, 1'b0}, 32'h8);

    normal(3'd3, TGT, 8'h50, 8'h86);
    normal(3'd1, TGT, 8'h50, 8'h00);
    normal(3'd2, TGT, 8'h00, 8'h50);
    normal(3'd0, TGT, 8'h00, 8'h00);

    glog = '0;
    @(negedge clk);
    req_valid = 1; req_op = 3'd0; req_addr = TGT;
    @(negedge clk);
    req_valid = 0;
    chk(glog[2:0] == 3'b100, "R1 first byte carries start", glog[2:0], 3'b100);
    repeat (30) @(negedge clk);

    run(3'd2, 7'h32, 8'h00, 8'h11, st, rd, cyc);
    chk(st == 2'd1 && glog == 24'o0000_0042 && ngo == 2, "R7 address nack then stop", glog, 24'o42);

    run(3'd5, TGT, 8'h10, 8'h20, st, rd, cyc);
    chk(st == 2'd3 && ngo == 0 && cyc == 1, "R6 unsupported rejected", {st, 8'(ngo), 8'(cyc)}, 32'h301);
    run(3'd7, TGT, 8'h10, 8'h20, st, rd, cyc);
    chk(st == 2'd3 && ngo == 0, "R6 unsupported op 7", {st, 8'(ngo)}, 32'h300);

    arb_mode = 1;
    run(3'd3, TGT, 8'h10, 8'h20, st, rd, cyc);
    arb_mode = 0;
    chk(st == 2'd2 && ngo == 1 && glog == 24'o4, "R8 arbitration lost no stop", {st, 8'(ngo)}, 32'h201);

    mute = 1; wait_limit = 8'd3;
    run(3'd2, TGT, 8'h00, 8'h44, st, rd, cyc);
    mute = 0;
    chk(st == 2'd3, "R9 timeout status", st, 3);
    chk(cyc >= 3 * TICKS && cyc <= 3 * TICKS + 10, "R9 timeout window", cyc, 3 * TICKS);
    chk(ngo == 1, "R9 no stop on timeout", ngo, 1);
    repeat (20) @(negedge clk);
    wait_limit = 8'd10;
    sel = 0;

    for (int i = 0; i < 60; i++) begin
      logic [2:0] op; logic [6:0] a;
      op = ($urandom % 10 == 0) ? 3'(4 + $urandom % 4) : 3'($urandom % 4);
      a = ($urandom % 8 == 0) ? 7'($urandom) : TGT;
      if (op[2]) begin
        run(op, a, 8'($urandom), 8'($urandom), st, rd, cyc);
        chk(st == 2'd3 && ngo == 0, "R6 random unsupported", st, 3);
      end else begin
        normal(op, a, 8'($urandom), 8'($urandom));
      end
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule